// File: doc/BRIEF.md
# Indexed Baud Tick Generator

This block produces the 16x-oversampling enable pulse that paces a UART's transmit and receive engines. Software selects the line rate by writing a small index byte, and a fixed lookup turns that index into one of ten standard rates: 9600, 19200, 38400, 57600, 115200, 230400, 460800, 921600, 1843200 and 3250000 baud (index 0 through 9).

The pulse is derived from a single 52 MHz reference clock, which is exactly sixteen times the fastest rate. A phase accumulator adds sixteen times the selected rate on every reference cycle. Whenever the sum reaches the reference frequency, the reference frequency is subtracted and a one-cycle tick is issued. Rates that do not divide the reference evenly therefore still hold the correct average. The byte last written can be read back at any time.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the readback is 0 and the tick is low. Index 0 (9600 baud) is in effect, so the first tick follows 339 clock edges after reset is released.
- R2: The readback output returns the full 8-bit byte of the most recent write, including values above 9. It holds its value while no write occurs.
- R3: A written index above 9 behaves exactly like index 9.
- R4: For an effective index i with rate B(i), the accumulator adds 16*B(i) on each clock edge. Over N edges following a write, the block issues floor(N*16*B(i)/52000000) ticks.
- R5: A write clears the accumulator and the pending tick. The tick is low in the cycle after the write edge, and the first tick comes ceil(52000000/(16*B(i))) edges later. This applies even when the same index is written again.
- R6: At effective index 9 the tick is high on every cycle that follows a non-write edge.
- R7: Each tick lasts one cycle. For indices 0 to 7 two ticks are never adjacent.
- R8: The accumulator value always stays below the reference frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 52 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the rate index byte |
| wr_data | input | 8 | Rate index byte to be written |
| rd_index | output | 8 | Readback of the last byte written |
| tick | output | 1 | One-cycle 16x oversampling enable |

## Verification
The bench counts ticks over a fixed window at every index and compares the total with the floor of the exact fractional ratio. A divider that rounds its increment, or that subtracts too early or too late, drifts off that count. It also measures the position of the first tick after reset, after a write, and after rewriting the same index. A design that keeps the old phase across a write puts the first tick early. Bytes above 9 are written to confirm both the raw readback and the clamp to the top rate. A design that wraps the index instead of clamping it would tick slowly rather than on every cycle.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  localparam int unsigned NUM_RATES = 10;
  localparam int unsigned IDX_W     = $clog2(NUM_RATES);

  // Line rate in baud for a table position.
  function automatic int unsigned rate_of(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0:    return 9600;
      4'd1:    return 19200;
      4'd2:    return 38400;
      4'd3:    return 57600;
      4'd4:    return 115200;
      4'd5:    return 230400;
      4'd6:    return 460800;
      4'd7:    return 921600;
      4'd8:    return 1843200;
      default: return 3250000;
    endcase
  endfunction

  // Phase step per reference cycle.
  function automatic int unsigned step_of(input logic [IDX_W-1:0] idx,
                                          input int unsigned oversample);
    return rate_of(idx) * oversample;
  endfunction

  // Saturate a raw register byte onto the table.
  function automatic logic [IDX_W-1:0] clamp_idx(input logic [7:0] raw);
    if (raw > 8'(NUM_RATES - 1)) return IDX_W'(NUM_RATES - 1);
    return raw[IDX_W-1:0];
  endfunction

endpackage

// File: rtl/baud_idx_reg.sv
module baud_idx_reg
  import baud_tick_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] raw_q,
  output logic [IDX_W-1:0] eff_idx
);

  always_ff @(posedge clk) begin
    if (!rst_n)     raw_q <= '0;
    else if (wr_en) raw_q <= wr_data;
  end

  assign eff_idx = clamp_idx(raw_q);

endmodule

// File: rtl/baud_rate_lut.sv
module baud_rate_lut
  import baud_tick_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned ACC_W      = 27
) (
  input  logic [IDX_W-1:0] idx,
  output logic [ACC_W-1:0] step
);

  always_comb step = ACC_W'(step_of(idx, OVERSAMPLE));

endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
  parameter int unsigned REF_HZ = 52_000_000,
  parameter int unsigned ACC_W  = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc_q,
  output logic             tick_q
);

  localparam logic [ACC_W-1:0] LIMIT = ACC_W'(REF_HZ);

  logic [ACC_W-1:0] sum;
  logic             wrap;

  always_comb begin
    sum  = acc_q + step;
    wrap = (sum >= LIMIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= wrap ? (sum - LIMIT) : sum;
      tick_q <= wrap;
    end
  end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int unsigned REF_HZ     = 52_000_000,
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned REG_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_index,
  output logic             tick
);

  localparam int unsigned ACC_W = $clog2(2 * REF_HZ) + 1;

  logic [IDX_W-1:0] eff_idx;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] acc_val;

  baud_idx_reg #(.REG_W(REG_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .raw_q(rd_index), .eff_idx(eff_idx)
  );

  baud_rate_lut #(.OVERSAMPLE(OVERSAMPLE), .ACC_W(ACC_W)) u_lut (
    .idx(eff_idx), .step(step)
  );

  baud_phase_acc #(.REF_HZ(REF_HZ), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .restart(wr_en), .step(step),
    .acc_q(acc_val), .tick_q(tick)
  );

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int unsigned REF_HZ = 52_000_000,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned ACC_W  = 27
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_index,
  input logic             tick,
  input logic [IDX_W-1:0] eff_idx,
  input logic [ACC_W-1:0] acc_val
);

  // R2
  readback_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_index == $past(wr_data));

  // R2
  readback_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_index));

  // R3
  index_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data > REG_W'(9)) |=> eff_idx == IDX_W'(9));

  // R5
  write_clears_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tick);

  // R6
  top_rate_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && eff_idx == IDX_W'(9)) |=> tick);

  // R7
  no_adjacent_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && eff_idx <= IDX_W'(7) && !wr_en) |=> !tick);

  // R8
  acc_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_val < ACC_W'(REF_HZ));

endmodule

bind baud_tick_gen baud_tick_gen_chk #(
  .REF_HZ(REF_HZ), .REG_W(REG_W), .IDX_W(baud_tick_pkg::IDX_W), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_index(rd_index), .tick(tick), .eff_idx(eff_idx), .acc_val(acc_val)
);

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;

  localparam longint REFC = 52_000_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_index;
  logic       tick;

  int checks = 0;
  int errors = 0;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_index(rd_index), .tick(tick)
  );

  always #4 clk = ~clk;

  function automatic longint bench_rate(input int i);
    longint r;
    case (i)
      0: r = 9600;     1: r = 19200;   2: r = 38400;   3: r = 57600;
      4: r = 115200;   5: r = 230400;  6: r = 460800;  7: r = 921600;
      8: r = 1843200;  default: r = 3250000;
    endcase
    return r * 16;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int n, output int first, output int cnt);
    first = -1; cnt = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (tick) begin
        cnt++;
        if (first < 0) first = k;
      end
    end
  endtask

  task automatic t_reset();
    int f, c;
    repeat (3) @(negedge clk);
    check(rd_index == 8'd0, "R1 readback", rd_index, 0);
    check(tick == 1'b0, "R1 tick", tick, 0);
    rst_n = 1'b1;
    measure(400, f, c);
    check(f == 339, "R1 first tick", f, 339);
  endtask

  task automatic t_rate(input int idx, input int n);
    int f, c;
    longint s;
    s = bench_rate(idx);
    do_write(8'(idx));
    check(tick == 1'b0, "R5 tick after write", tick, 0);
    check(rd_index == 8'(idx), "R2 readback", rd_index, idx);
    measure(n, f, c);
    check(f == int'((REFC + s - 1) / s), "R5 first tick", f, (REFC + s - 1) / s);
    check(c == int'((longint'(n) * s) / REFC), "R4 tick count", c, (longint'(n) * s) / REFC);
    check(rd_index == 8'(idx), "R2 readback held", rd_index, idx);
  endtask

  task automatic t_clamp(input logic [7:0] v);
    int f, c;
    do_write(v);
    check(rd_index == v, "R2 raw readback", rd_index, v);
    measure(50, f, c);
    check(c == 50, "R3 clamp to top rate", c, 50);
    check(f == 1, "R6 top rate first tick", f, 1);
  endtask

  task automatic t_rewrite();
    int f, c;
    do_write(8'd5);
    measure(20, f, c);
    do_write(8'd5);
    check(tick == 1'b0, "R5 rewrite clears tick", tick, 0);
    measure(20, f, c);
    check(f == 15, "R5 rewrite restarts phase", f, 15);
  endtask

  initial begin
    t_reset();
    for (int i = 0; i < 10; i++) t_rate(i, 3000);
    t_clamp(8'd10);
    t_clamp(8'd255);
    t_rewrite();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule